// File: doc/BRIEF.md
# Byte Parity Checker and Generator

This block sits on a data path that carries 36-bit words made of four 9-bit bytes. In each byte, bit 8 holds the parity bit and bits 7:0 hold the payload. For every accepted word, the block checks the parity of the incoming bytes against a programmable sense, odd or even, and raises a parity-error flag when a checked byte is wrong.

It can also regenerate parity. In that mode it computes a fresh parity bit over each selected byte's low eight bits and writes it into bit 8 of the outgoing word. The new bit replaces whatever value bit 8 carried on the way in.

Checking and generation each have their own granularity setting: the full word, the low half-word, or the low byte. Bytes outside the selected span are neither checked nor modified. The error flag follows each word in flowthrough mode. In latched mode it holds an error until software rewrites the control register or reset is applied.

A small readable control register holds all settings. The word, its valid bit and the flag all leave the block registered, on the clock edge that accepts the word.

Top module: `byte_parity_unit`

## Requirements
- R1: After reset, cfg_rdata_o is 0 (odd sense, full-word check, generation off, flowthrough flag), valid_o is 0 and perr_o is 0.
- R2: A write with cfg_we_i high loads cfg_wdata_i into the control register. The new value appears on cfg_rdata_o one cycle later, and the register holds its value while cfg_we_i is low. The fields are: bit 0 parity sense, bits 2:1 check span, bits 4:3 generate span, bit 5 generate enable, bit 6 latched flag.
- R3: Parity sense bit 0 = 0 selects odd parity: a byte is correct when its nine bits hold an odd number of ones. Bit 0 = 1 selects even parity: the byte is correct when the count is even.
- R4: The check span field selects which bytes are checked. Codes 00 and 11 check bytes 0 to 3. Code 01 checks bytes 0 to 1 (bits 17:0). Code 10 checks byte 0 (bits 8:0). A parity fault in any byte outside the span does not raise perr_o.
- R5: With bit 5 set, every byte in the generate span (same span codes as R4) leaves the block with bit 8 set so that the byte meets the current parity sense. The new bit 8 is computed from bits 7:0 only.
- R6: Bits 7:0 of every byte pass through unchanged. Bit 8 of any byte that is not generated also passes through unchanged.
- R7: A word accepted with valid_i high appears on word_o, with valid_o high, one cycle later. In a cycle without valid_i, valid_o is low and word_o holds its last value.
- R8: Checking judges the incoming bits, so a bad input byte raises perr_o even when its parity is regenerated on the way out.
- R9: In flowthrough mode (bit 6 = 0), perr_o takes the result of each accepted word, falling on a good word. It holds its value through cycles without a word.
- R10: In latched mode (bit 6 = 1), once perr_o is set it stays set through later good words until a control register write or reset clears it.
- R11: A word accepted in the same cycle as a control write is processed under the settings in force before the write. After the write, perr_o reflects only that word's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 7 | Control register write value |
| cfg_rdata_o | output | 7 | Control register contents |
| valid_i | input | 1 | Word accepted this cycle |
| word_i | input | 36 | Incoming word, four 9-bit bytes |
| valid_o | output | 1 | Registered word is new |
| word_o | output | 36 | Registered word with generated parity |
| perr_o | output | 1 | Parity-error flag |

## Verification
A wrong span mask shows up one cycle after the first word that carries a fault in a byte on the span edge. The flag is then wrong, or bit 8 of that byte is left unrepaired. A sense bit stuck at its reset value makes every word in even mode look bad from the first accepted word. A latched flag that leaks shows up as perr_o falling on the first good word after an error. A stale flag left behind by a control write shows up one cycle after that write.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int CFG_W = 7;

  typedef enum logic [1:0] {
    GRAN_WORD = 2'b00,
    GRAN_HALF = 2'b01,
    GRAN_BYTE = 2'b10,
    GRAN_ALL  = 2'b11
  } gran_e;

  typedef struct packed {
    logic  flag_latch;
    logic  gen_en;
    gran_e gen_gran;
    gran_e chk_gran;
    logic  even;
  } cfg_t;
endpackage

// File: rtl/bpc_gran_mask.sv
module bpc_gran_mask
  import bpc_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  gran_e             gran_i,
  output logic [BYTES-1:0]  mask_o
);
  localparam int HALF = (BYTES / 2 > 0) ? BYTES / 2 : 1;

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    always_comb begin
      unique case (gran_i)
        GRAN_HALF: mask_o[i] = (i < HALF);
        GRAN_BYTE: mask_o[i] = (i == 0);
        default:   mask_o[i] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/bpc_cfg_reg.sv
module bpc_cfg_reg
  import bpc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= cfg_t'(wdata_i);
  end

  assign cfg_o = cfg_q;

  a_r2_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/bpc_lane.sv
module bpc_lane #(
  parameter int BYTE_W = 9
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              even_i,
  input  logic              chk_i,
  input  logic              gen_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              bad_o
);
  localparam int PAY_W = BYTE_W - 1;

  logic [PAY_W-1:0] pay;
  logic             pay_par;
  logic             full_par;

  assign pay      = byte_i[PAY_W-1:0];
  assign pay_par  = ^pay;
  assign full_par = pay_par ^ byte_i[BYTE_W-1];

  // odd sense wants full_par=1, even wants 0
  assign bad_o  = chk_i & (full_par == even_i);
  assign byte_o = gen_i ? {pay_par ^ ~even_i, pay} : byte_i;
endmodule

// File: rtl/bpc_err_flag.sv
module bpc_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic err_i,
  input  logic latch_i,
  input  logic clr_i,
  output logic perr_o
);
  logic hit;
  logic perr_q;

  assign hit = valid_i & err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      perr_q <= 1'b0;
    else if (clr_i)   perr_q <= hit;
    else if (latch_i) perr_q <= perr_q | hit;
    else if (valid_i) perr_q <= err_i;
  end

  assign perr_o = perr_q;

  a_r10_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_o && latch_i && !clr_i) |=> perr_o);
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> $stable(perr_o));
  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(valid_i && err_i)) |=> !perr_o);
endmodule

// File: rtl/byte_parity_unit.sv
module byte_parity_unit
  import bpc_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [CFG_W-1:0]        cfg_wdata_i,
  output logic [CFG_W-1:0]        cfg_rdata_o,
  input  logic                    valid_i,
  input  logic [BYTES*BYTE_W-1:0] word_i,
  output logic                    valid_o,
  output logic [BYTES*BYTE_W-1:0] word_o,
  output logic                    perr_o
);
  localparam int WORD_W = BYTES * BYTE_W;
  localparam int PAY_W  = BYTE_W - 1;

  cfg_t              cfg;
  logic [BYTES-1:0]  chk_mask;
  logic [BYTES-1:0]  gen_mask;
  logic [BYTES-1:0]  bad;
  logic [WORD_W-1:0] word_d;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;

  bpc_cfg_reg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (cfg)
  );

  assign cfg_rdata_o = cfg;

  bpc_gran_mask #(.BYTES(BYTES)) u_chk_mask (.gran_i(cfg.chk_gran), .mask_o(chk_mask));
  bpc_gran_mask #(.BYTES(BYTES)) u_gen_mask (.gran_i(cfg.gen_gran), .mask_o(gen_mask));

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    bpc_lane #(.BYTE_W(BYTE_W)) u_lane (
      .byte_i(word_i[i*BYTE_W +: BYTE_W]),
      .even_i(cfg.even),
      .chk_i (chk_mask[i]),
      .gen_i (cfg.gen_en & gen_mask[i]),
      .byte_o(word_d[i*BYTE_W +: BYTE_W]),
      .bad_o (bad[i])
    );

    a_r6_payload_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> word_o[i*BYTE_W +: PAY_W] == $past(word_i[i*BYTE_W +: PAY_W]));
    a_r5_gen_sense: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && cfg.gen_en && gen_mask[i])
        |=> ((^word_o[i*BYTE_W +: BYTE_W]) != $past(cfg.even)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) word_q <= word_d;
    end
  end

  assign valid_o = valid_q;
  assign word_o  = word_q;

  bpc_err_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .err_i  (|bad),
    .latch_i(cfg.flag_latch),
    .clr_i  (cfg_we_i),
    .perr_o (perr_o)
  );

  a_r7_valid_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(word_o)));
endmodule

// File: tb/byte_parity_unit_tb_top.sv
module byte_parity_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_wdata = '0;
  logic [6:0]  cfg_rdata;
  logic        valid_in = 1'b0;
  logic [35:0] word_in = '0;
  logic        valid_out;
  logic [35:0] word_out;
  logic        perr;

  always #2 clk = ~clk;

  byte_parity_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .valid_i(valid_in), .word_i(word_in),
    .valid_o(valid_out), .word_o(word_out), .perr_o(perr)
  );

  typedef struct {
    logic [35:0] word;
    logic        perr;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_run = 0;
  int          n_fail = 0;
  logic [6:0]  m_cfg = '0;
  logic        m_perr = 1'b0;
  logic [35:0] last_out = '0;
  bit          done = 0;

  function automatic logic [3:0] span(logic [1:0] g);
    case (g)
      2'b01:   return 4'b0011;
      2'b10:   return 4'b0001;
      default: return 4'b1111;
    endcase
  endfunction

  // good bytes for given sense, bit8 flipped where flip is set
  function automatic logic [35:0] mk(logic [31:0] pay, logic even, logic [3:0] flip);
    logic [35:0] w;
    for (int i = 0; i < 4; i++) begin
      w[i*9 +: 8] = pay[i*8 +: 8];
      w[i*9 + 8]  = (^pay[i*8 +: 8]) ^ ~even ^ flip[i];
    end
    return w;
  endfunction

  task automatic check(string req, logic [35:0] act, logic [35:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, starting at a negedge
  task automatic cycle(logic v, logic [35:0] w, logic we, logic [6:0] wd, string tag);
    logic        err = 1'b0;
    logic [35:0] o = w;
    logic [3:0]  cm = span(m_cfg[2:1]);
    logic [3:0]  gm = span(m_cfg[4:3]);
    exp_t        e;
    valid_in  = v;
    word_in   = w;
    cfg_we    = we;
    cfg_wdata = wd;
    if (v) begin
      for (int i = 0; i < 4; i++) begin
        if (cm[i] && ((^w[i*9 +: 9]) == m_cfg[0])) err = 1'b1;
        if (m_cfg[5] && gm[i]) o[i*9 + 8] = (^w[i*9 +: 8]) ^ ~m_cfg[0];
      end
    end
    if (we) begin
      m_perr = err;
      m_cfg  = wd;
    end else if (v) begin
      m_perr = m_cfg[6] ? (m_perr | err) : err;
    end
    if (v) begin
      e.word = o;
      e.perr = m_perr;
      e.tag  = tag;
      sb.push_back(e);
    end
    @(negedge clk);
    valid_in = 1'b0;
    cfg_we   = 1'b0;
  endtask

  task automatic wr_cfg(logic [6:0] wd);
    cycle(1'b0, '0, 1'b1, wd, "R2");
    check("R2 cfg readback", {29'd0, cfg_rdata}, {29'd0, wd});
    check("R11 flag cleared by write", {35'd0, perr}, 36'd0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_out) begin
      exp_t e;
      n_run++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected word: actual %h expected none", word_out);
      end else begin
        e = sb.pop_front();
        if (word_out !== e.word || perr !== e.perr) begin
          n_fail++;
          $display("FAIL %s: actual %h/%b expected %h/%b", e.tag, word_out, perr, e.word, e.perr);
        end
        last_out = word_out;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cfg reset", {29'd0, cfg_rdata}, 36'd0);
    check("R1 valid_o reset", {35'd0, valid_out}, 36'd0);
    check("R1 perr reset", {35'd0, perr}, 36'd0);

    // R3 odd sense, R4 full span
    cycle(1, mk(32'hA5C3_0F11, 0, 4'b0000), 0, 0, "R3 odd good");
    cycle(1, mk(32'h1234_5678, 0, 4'b1000), 0, 0, "R4 byte3 fault full span");
    cycle(1, mk(32'hFFFF_0000, 0, 4'b0000), 0, 0, "R9 flow falls on good");
    cycle(0, '0, 0, 0, "idle");
    check("R7 idle valid_o", {35'd0, valid_out}, 36'd0);
    check("R7 idle word hold", word_out, last_out);
    check("R9 idle perr hold", {35'd0, perr}, 36'd0);

    // R3 even sense
    wr_cfg(7'b000_0001);
    cycle(1, mk(32'hA5C3_0F11, 0, 4'b0000), 0, 0, "R3 odd word under even");
    cycle(1, mk(32'hA5C3_0F11, 1, 4'b0000), 0, 0, "R3 even good");

    // R4 half span: byte3 fault ignored, byte1 fault seen
    wr_cfg(7'b000_0010);
    cycle(1, mk(32'h0102_0304, 0, 4'b1100), 0, 0, "R4 half ignores upper");
    cycle(1, mk(32'h0102_0304, 0, 4'b0010), 0, 0, "R4 half byte1 fault");
    // R4 byte span
    wr_cfg(7'b000_0100);
    cycle(1, mk(32'h7E7E_7E7E, 0, 4'b1110), 0, 0, "R4 byte span ignores 1..3");
    cycle(1, mk(32'h7E7E_7E7E, 0, 4'b0001), 0, 0, "R4 byte0 fault");
    wr_cfg(7'b000_0110);
    cycle(1, mk(32'h3C3C_3C3C, 0, 4'b1000), 0, 0, "R4 code 11 full");

    // R5/R6/R8 generation
    wr_cfg(7'b010_0000);
    cycle(1, mk(32'hDEAD_BEEF, 0, 4'b1111), 0, 0, "R8 bad in, R5 fixed out");
    wr_cfg(7'b010_1001);
    cycle(1, mk(32'hCAFE_0123, 1, 4'b1111), 0, 0, "R5 half gen even, R6 upper pass");
    wr_cfg(7'b011_0100);
    cycle(1, mk(32'h5555_AAAA, 0, 4'b1111), 0, 0, "R5 byte gen, R6 bytes1..3 pass");

    // R10 latched
    wr_cfg(7'b100_0000);
    cycle(1, mk(32'h0000_0001, 0, 4'b0100), 0, 0, "R10 latch set");
    cycle(1, mk(32'h0000_0002, 0, 4'b0000), 0, 0, "R10 latch holds");
    cycle(0, '0, 0, 0, "idle");
    check("R10 latch holds idle", {35'd0, perr}, 36'd1);
    wr_cfg(7'b100_0000);

    // R11 write with word: old odd sense applies
    cycle(1, mk(32'h1111_2222, 0, 4'b0000), 1, 7'b100_0001, "R11 old cfg good");
    cycle(1, mk(32'h1111_2222, 0, 4'b0000), 0, 0, "R11 new even sense");
    cycle(1, mk(32'h1111_2222, 1, 4'b0001), 1, 7'b000_0000, "R11 old even bad");
    cycle(0, '0, 0, 0, "idle");
    cycle(0, '0, 0, 0, "idle");
    check("R11 scoreboard drained", {35'd0, sb.size() == 0}, 36'd1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule